// File: doc/BRIEF.md
# Security-Banked Floating-Point Control Register Bank

This block holds the floating-point system control registers of a microcontroller core that runs in a secure and a non-secure state. Software reaches it over a simple word bus: a byte offset, a write enable, write data, a secure-access attribute and a combinational read data return. Three static inputs shape its behaviour: whether the floating-point unit exists at all, whether the newer architecture feature set is present, and whether fault handling has been handed to the non-secure state.

Most registers keep one copy per security state, chosen by the access attribute. One register, the secure-only access-permission register, has a single copy that non-secure software can neither see nor change. The context-control register is the awkward one: some of its bits are held per state, while the rest exist once and belong to the secure side. Non-secure software sees a filtered view of those shared bits, and its writes reach them bit by bit, only where the secure side or the fault-handling flag allows. The block stores and masks values only; no lazy stacking or floating-point execution happens here.

Top module: `fp_ctl_bank`

## Requirements
- R1: With the FP-present input low, every offset reads 0 and writes change no stored value.
- R2: Any offset other than 0xD88, 0xD8C, 0xF34, 0xF38 and 0xF3C reads 0, and writes there change no register.
- R3: After reset the secure context-control copy is 0xC0000004 and the non-secure copy is 0x80000000; every other register is 0.
- R4: Bits 25:11 of the context-control register (0xF34) are always stored and read as 0.
- R5: Context-control bits 0, 1, 3, 5, 9, 10 and 31 are held per security state; a write from one state does not change the other state's copy of those bits.
- R6: A non-secure read of 0xF34 returns the secure copy masked to bits 30, 28 and 8, plus bits 6 and 4 when the fault-to-non-secure flag is high, ORed with the non-secure copy.
- R7: A non-secure write to 0xF34 updates secure bit 30 only if secure bit 29 is 0, secure bit 28 only if secure bit 27 is 0, secure bits 6 and 4 only if the fault-to-non-secure flag is high, and secure bit 8 always; the non-secure copy takes the written value masked to the per-state bits; no other secure bit changes. A secure write replaces the secure copy.
- R8: With the newer-feature input low, a write to 0xF34 keeps only bits 31, 30, 8, 6, 5, 4, 3, 1 and 0 of the written value.
- R9: The access register at 0xD88 is held per security state and stores only bits 23:20.
- R10: The register at 0xD8C has one copy storing only bits 11:10; non-secure reads return 0 and non-secure writes are ignored.
- R11: The context-address register at 0xF38 is held per security state and writes clear bits 2:0.
- R12: The default-status register at 0xF3C is held per security state and stores only bits 26:22.
- R13: Read data follows the offset and attribute in the same cycle; a write takes effect at the rising clock edge with the write enable high, so a read in the write cycle still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_present | input | 1 | Floating-point unit exists; low makes the bank read 0 and ignore writes |
| v8_feat | input | 1 | Newer architecture feature set present |
| fault_ns | input | 1 | Fault handling has been handed to the non-secure state |
| bus_addr | input | ADDR_W (12) | Byte offset of the accessed register |
| bus_sec | input | 1 | Access comes from the secure state |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from offset and attribute |

## Verification
A wrong stored bit in this bank stays invisible until the matching register is read from the right security state, so every write is followed by reads from both states, which shows a leak between copies on the very next read. Gating faults in the non-secure write path only appear on a later secure read of the shared bits, so each gate is exercised with its controlling bit both set and clear and the secure copy is read back right after. A wrong filter mask shows at once on a non-secure read of the context-control register, checked with the fault flag both high and low.

// File: rtl/fpcb_pkg.sv
package fpcb_pkg;

   localparam int unsigned REG_W = 32;

   localparam logic [11:0] OFS_ACC   = 12'hD88;
   localparam logic [11:0] OFS_NSACC = 12'hD8C;
   localparam logic [11:0] OFS_CTX   = 12'hF34;
   localparam logic [11:0] OFS_CADDR = 12'hF38;
   localparam logic [11:0] OFS_DSTAT = 12'hF3C;

   // context-control bit positions the write gates depend on
   localparam int unsigned CB_HF_RDY   = 4;
   localparam int unsigned CB_BF_RDY   = 6;
   localparam int unsigned CB_MON_RDY  = 8;
   localparam int unsigned CB_CLR_LOCK = 27;
   localparam int unsigned CB_CLR_RET  = 28;
   localparam int unsigned CB_LZ_LOCK  = 29;
   localparam int unsigned CB_LZ_EN    = 30;

   localparam logic [REG_W-1:0] CTX_PER_STATE = 32'h8000_062B;
   localparam logic [REG_W-1:0] CTX_RSVD      = 32'h03FF_F800;
   localparam logic [REG_W-1:0] CTX_OLD_KEEP  = 32'hC000_017B;
   localparam logic [REG_W-1:0] CTX_NS_VIEW   = 32'h5000_0100;
   localparam logic [REG_W-1:0] CTX_NS_FAULT  = 32'h0000_0050;
   localparam logic [REG_W-1:0] CTX_RST_S     = 32'hC000_0004;
   localparam logic [REG_W-1:0] CTX_RST_NS    = 32'h8000_0000;

   localparam logic [REG_W-1:0] ACC_KEEP   = 32'h00F0_0000;
   localparam logic [REG_W-1:0] NSACC_KEEP = 32'h0000_0C00;
   localparam logic [REG_W-1:0] CADDR_KEEP = 32'hFFFF_FFF8;
   localparam logic [REG_W-1:0] DSTAT_KEEP = 32'h07C0_0000;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ACC,
      SEL_NSACC,
      SEL_CTX,
      SEL_CADDR,
      SEL_DSTAT
   } reg_sel_e;

endpackage

// File: rtl/fpcb_bank_reg.sv
module fpcb_bank_reg #(
   parameter int unsigned        DATA_W = 32,
   parameter logic [DATA_W-1:0]  KEEP   = '1,
   parameter bit                 BANKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sec,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (BANKED) begin : g_two_copies
         logic [DATA_W-1:0] q_s;
         logic [DATA_W-1:0] q_ns;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_s  <= '0;
               q_ns <= '0;
            end else if (wr) begin
               if (sec) q_s  <= wdata & KEEP;
               else     q_ns <= wdata & KEEP;
            end
         end

         assign rdata = sec ? q_s : q_ns;
      end else begin : g_secure_only
         logic [DATA_W-1:0] q_s;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q_s <= '0;
            else if (wr && sec)  q_s <= wdata & KEEP;
         end

         assign rdata = sec ? q_s : '0;
      end
   endgenerate

endmodule

// File: rtl/fpcb_ctx_reg.sv
module fpcb_ctx_reg
   import fpcb_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sec,
   input  logic              v8_feat,
   input  logic              fault_ns,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] q_s;
   logic [DATA_W-1:0] q_ns;
   logic [DATA_W-1:0] wval;
   logic [DATA_W-1:0] ns_gate;
   logic [DATA_W-1:0] s_next;
   logic [DATA_W-1:0] view_mask;

   // written value after feature and reserved masking
   always_comb begin
      wval = wdata & ~CTX_RSVD;
      if (!v8_feat) wval = wval & CTX_OLD_KEEP;
   end

   // shared bits a non-secure write may reach
   always_comb begin
      ns_gate = '0;
      ns_gate[CB_MON_RDY] = 1'b1;
      ns_gate[CB_LZ_EN]   = ~q_s[CB_LZ_LOCK];
      ns_gate[CB_CLR_RET] = ~q_s[CB_CLR_LOCK];
      ns_gate[CB_HF_RDY]  = fault_ns;
      ns_gate[CB_BF_RDY]  = fault_ns;
   end

   assign s_next = sec ? wval : ((q_s & ~ns_gate) | (wval & ns_gate));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_s  <= CTX_RST_S;
         q_ns <= CTX_RST_NS;
      end else if (wr) begin
         q_s <= s_next;
         if (!sec) q_ns <= wval & CTX_PER_STATE;
      end
   end

   assign view_mask = fault_ns ? (CTX_NS_VIEW | CTX_NS_FAULT) : CTX_NS_VIEW;
   assign rdata     = sec ? q_s : ((q_s & view_mask) | q_ns);

endmodule

// File: rtl/fp_ctl_bank.sv
module fp_ctl_bank
   import fpcb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_present,
   input  logic              v8_feat,
   input  logic              fault_ns,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_sec,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int unsigned N_REGS = 5;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("fp_ctl_bank: DATA_W must equal the register width");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("fp_ctl_bank: ADDR_W too narrow for the register offsets");
   end

   reg_sel_e          sel;
   logic [N_REGS-1:0] wr_vec;
   logic [DATA_W-1:0] rd_acc, rd_nsacc, rd_ctx, rd_caddr, rd_dstat;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == ADDR_W'(OFS_ACC))   sel = SEL_ACC;
      else if (bus_addr == ADDR_W'(OFS_NSACC)) sel = SEL_NSACC;
      else if (bus_addr == ADDR_W'(OFS_CTX))   sel = SEL_CTX;
      else if (bus_addr == ADDR_W'(OFS_CADDR)) sel = SEL_CADDR;
      else if (bus_addr == ADDR_W'(OFS_DSTAT)) sel = SEL_DSTAT;
   end

   always_comb begin
      wr_vec = '0;
      if (bus_we && fp_present) begin
         case (sel)
            SEL_ACC:   wr_vec[0] = 1'b1;
            SEL_NSACC: wr_vec[1] = 1'b1;
            SEL_CTX:   wr_vec[2] = 1'b1;
            SEL_CADDR: wr_vec[3] = 1'b1;
            SEL_DSTAT: wr_vec[4] = 1'b1;
            default:   wr_vec    = '0;
         endcase
      end
   end

   fpcb_bank_reg #(.DATA_W(DATA_W), .KEEP(ACC_KEEP), .BANKED(1'b1)) u_acc (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[0]), .sec(bus_sec),
      .wdata(bus_wdata), .rdata(rd_acc));

   fpcb_bank_reg #(.DATA_W(DATA_W), .KEEP(NSACC_KEEP), .BANKED(1'b0)) u_nsacc (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[1]), .sec(bus_sec),
      .wdata(bus_wdata), .rdata(rd_nsacc));

   fpcb_ctx_reg #(.DATA_W(DATA_W)) u_ctx (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[2]), .sec(bus_sec),
      .v8_feat(v8_feat), .fault_ns(fault_ns),
      .wdata(bus_wdata), .rdata(rd_ctx));

   fpcb_bank_reg #(.DATA_W(DATA_W), .KEEP(CADDR_KEEP), .BANKED(1'b1)) u_caddr (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[3]), .sec(bus_sec),
      .wdata(bus_wdata), .rdata(rd_caddr));

   fpcb_bank_reg #(.DATA_W(DATA_W), .KEEP(DSTAT_KEEP), .BANKED(1'b1)) u_dstat (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[4]), .sec(bus_sec),
      .wdata(bus_wdata), .rdata(rd_dstat));

   always_comb begin
      case (sel)
         SEL_ACC:   rd_mux = rd_acc;
         SEL_NSACC: rd_mux = rd_nsacc;
         SEL_CTX:   rd_mux = rd_ctx;
         SEL_CADDR: rd_mux = rd_caddr;
         SEL_DSTAT: rd_mux = rd_dstat;
         default:   rd_mux = '0;
      endcase
   end

   assign bus_rdata = fp_present ? rd_mux : '0;

endmodule

// File: rtl/fp_ctl_bank_chk.sv
module fp_ctl_bank_chk
   import fpcb_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fp_present,
   input logic              v8_feat,
   input logic              fault_ns,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_sec,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata
);

   logic at_acc, at_nsacc, at_ctx, at_caddr, at_dstat, at_any;
   assign at_acc   = bus_addr == ADDR_W'(OFS_ACC);
   assign at_nsacc = bus_addr == ADDR_W'(OFS_NSACC);
   assign at_ctx   = bus_addr == ADDR_W'(OFS_CTX);
   assign at_caddr = bus_addr == ADDR_W'(OFS_CADDR);
   assign at_dstat = bus_addr == ADDR_W'(OFS_DSTAT);
   assign at_any   = at_acc | at_nsacc | at_ctx | at_caddr | at_dstat;

   assert_absent_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fp_present |-> bus_rdata == '0);

   assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !at_any |-> bus_rdata == '0);

   assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      at_ctx |-> bus_rdata[25:11] == '0);

   // shared-only bits 2, 26, 27, 29 never reach a non-secure read
   assert_ns_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (at_ctx && !bus_sec) |-> (bus_rdata[2] == 1'b0 && bus_rdata[26] == 1'b0
                                && bus_rdata[27] == 1'b0 && bus_rdata[29] == 1'b0));

   assert_acc_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      at_acc |-> (bus_rdata & ~ACC_KEEP) == '0);

   assert_nsacc_hidden_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (at_nsacc && !bus_sec) |-> bus_rdata == '0);

   assert_caddr_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
      at_caddr |-> bus_rdata[2:0] == 3'b000);

   assert_dstat_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
      at_dstat |-> (bus_rdata & ~DSTAT_KEEP) == '0);

   assert_read_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(bus_addr) && $stable(bus_sec) && $stable(fp_present) && $stable(v8_feat)
       && $stable(fault_ns) && !$past(bus_we)) |-> $stable(bus_rdata));

endmodule

bind fp_ctl_bank fp_ctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fp_present(fp_present), .v8_feat(v8_feat),
   .fault_ns(fault_ns), .bus_addr(bus_addr), .bus_sec(bus_sec),
   .bus_we(bus_we), .bus_rdata(bus_rdata));

// File: tb/tb_fp_ctl_bank.sv
`timescale 1ns/1ps
module tb_fp_ctl_bank;

   localparam int N_VEC = 35;
   // {write, secure, offset, data (write value or expected read), requirement}
   localparam logic [49:0] VEC [0:N_VEC-1] = '{
      {1'b0, 1'b1, 12'hF34, 32'hC000_0004, 4'd3},  // R3 secure reset
      {1'b0, 1'b0, 12'hF34, 32'hC000_0000, 4'd3},  // R3 non-secure reset view
      {1'b1, 1'b1, 12'hF34, 32'hFFFF_FFFF, 4'd4},
      {1'b0, 1'b1, 12'hF34, 32'hFC00_07FF, 4'd4},  // R4 reserved cleared
      {1'b0, 1'b0, 12'hF34, 32'hD000_0100, 4'd6},  // R6 filtered view
      {1'b1, 1'b0, 12'hF34, 32'h0000_0000, 4'd7},
      {1'b0, 1'b1, 12'hF34, 32'hFC00_06FF, 4'd7},  // R7 locks hold, bit 8 follows
      {1'b0, 1'b0, 12'hF34, 32'h5000_0000, 4'd5},  // R5 per-state copy
      {1'b1, 1'b1, 12'hF34, 32'h0000_0000, 4'd7},
      {1'b1, 1'b0, 12'hF34, 32'hFFFF_FFFF, 4'd7},
      {1'b0, 1'b1, 12'hF34, 32'h5000_0100, 4'd7},  // R7 unlocked bits follow
      {1'b0, 1'b0, 12'hF34, 32'hD000_072B, 4'd5},  // R5
      {1'b1, 1'b1, 12'hD88, 32'hFFFF_FFFF, 4'd9},
      {1'b0, 1'b1, 12'hD88, 32'h00F0_0000, 4'd9},  // R9
      {1'b0, 1'b0, 12'hD88, 32'h0000_0000, 4'd9},
      {1'b1, 1'b0, 12'hD88, 32'h0050_0000, 4'd9},
      {1'b0, 1'b0, 12'hD88, 32'h0050_0000, 4'd9},
      {1'b0, 1'b1, 12'hD88, 32'h00F0_0000, 4'd9},
      {1'b1, 1'b1, 12'hD8C, 32'hFFFF_FFFF, 4'd10},
      {1'b0, 1'b1, 12'hD8C, 32'h0000_0C00, 4'd10}, // R10
      {1'b0, 1'b0, 12'hD8C, 32'h0000_0000, 4'd10},
      {1'b1, 1'b0, 12'hD8C, 32'h0000_0000, 4'd10},
      {1'b0, 1'b1, 12'hD8C, 32'h0000_0C00, 4'd10},
      {1'b1, 1'b1, 12'hF38, 32'hFFFF_FFFF, 4'd11},
      {1'b1, 1'b0, 12'hF38, 32'h1234_5677, 4'd11},
      {1'b0, 1'b1, 12'hF38, 32'hFFFF_FFF8, 4'd11}, // R11
      {1'b0, 1'b0, 12'hF38, 32'h1234_5670, 4'd11},
      {1'b1, 1'b1, 12'hF3C, 32'hFFFF_FFFF, 4'd12},
      {1'b1, 1'b0, 12'hF3C, 32'h0540_0001, 4'd12},
      {1'b0, 1'b1, 12'hF3C, 32'h07C0_0000, 4'd12}, // R12
      {1'b0, 1'b0, 12'hF3C, 32'h0540_0000, 4'd12},
      {1'b1, 1'b1, 12'hD89, 32'h0000_0000, 4'd2},
      {1'b0, 1'b1, 12'hD89, 32'h0000_0000, 4'd2},  // R2 unmapped
      {1'b0, 1'b1, 12'hD88, 32'h00F0_0000, 4'd2},
      {1'b0, 1'b0, 12'hF30, 32'h0000_0000, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fp_present = 1'b1;
   logic        v8_feat = 1'b1;
   logic        fault_ns = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_sec = 1'b0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fp_ctl_bank dut (
      .clk(clk), .rst_n(rst_n), .fp_present(fp_present), .v8_feat(v8_feat),
      .fault_ns(fault_ns), .bus_addr(bus_addr), .bus_sec(bus_sec),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic do_wr(input logic sec, input logic [11:0] addr, input logic [31:0] data);
      @(negedge clk);
      bus_sec = sec; bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic do_rd(input logic sec, input logic [11:0] addr, input logic [31:0] exp,
                        input string req);
      @(negedge clk);
      bus_we = 1'b0; bus_sec = sec; bus_addr = addr;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s: offset %h sec %0d read %h expected %h", req, addr, sec, bus_rdata, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < N_VEC; i++) begin
         if (VEC[i][49]) do_wr(VEC[i][48], VEC[i][47:36], VEC[i][35:4]);
         else            do_rd(VEC[i][48], VEC[i][47:36], VEC[i][35:4],
                               $sformatf("R%0d", VEC[i][3:0]));
      end

      // R13: old value visible during the write cycle, new value after the edge
      @(negedge clk);
      bus_sec = 1'b1; bus_addr = 12'hF38; bus_wdata = 32'h0; bus_we = 1'b1;
      #1;
      checks++;
      if (bus_rdata !== 32'hFFFF_FFF8) begin
         errors++;
         $display("FAIL R13: write-cycle read %h expected %h", bus_rdata, 32'hFFFF_FFF8);
      end
      @(negedge clk);
      bus_we = 1'b0;
      #1;
      checks++;
      if (bus_rdata !== 32'h0) begin
         errors++;
         $display("FAIL R13: post-edge read %h expected %h", bus_rdata, 32'h0);
      end

      // R7 / R6 with fault flag: locks clear, fault bits writable from non-secure
      fault_ns = 1'b1;
      do_wr(1'b0, 12'hF34, 32'h0000_0050);
      do_rd(1'b0, 12'hF34, 32'h0000_0050, "R6");
      do_rd(1'b1, 12'hF34, 32'h0000_0050, "R7");
      fault_ns = 1'b0;
      do_rd(1'b0, 12'hF34, 32'h0000_0000, "R6");

      // R7 lock: lazy-enable held when its lock bit is set
      do_wr(1'b1, 12'hF34, 32'h6000_0000);
      do_wr(1'b0, 12'hF34, 32'h0000_0000);
      do_rd(1'b1, 12'hF34, 32'h6000_0000, "R7");

      // R8: older feature set keeps a reduced field set
      v8_feat = 1'b0;
      do_wr(1'b1, 12'hF34, 32'hFFFF_FFFF);
      do_rd(1'b1, 12'hF34, 32'hC000_017B, "R8");
      do_wr(1'b0, 12'hF34, 32'hFFFF_FFFF);
      do_rd(1'b0, 12'hF34, 32'hC000_012B, "R8");
      v8_feat = 1'b1;

      // R1: absent unit reads zero and ignores writes
      fp_present = 1'b0;
      do_rd(1'b1, 12'hF34, 32'h0, "R1");
      do_wr(1'b1, 12'hD88, 32'h0);
      fp_present = 1'b1;
      do_rd(1'b1, 12'hD88, 32'h00F0_0000, "R1");

      // R3: reset in mid-run restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_rd(1'b1, 12'hF34, 32'hC000_0004, "R3");
      do_rd(1'b0, 12'hF34, 32'hC000_0000, "R3");
      do_rd(1'b1, 12'hD88, 32'h0, "R3");
      do_rd(1'b1, 12'hD8C, 32'h0, "R3");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule